// File: doc/BRIEF.md
# Key-Locked Indexed Configuration Port

This block holds a bank of 256 byte-wide configuration registers. They are reached through two adjacent I/O addresses on a simple host bus. The even address is the index port and the odd address is the data port. The bank powers up sealed. Software must first write an unlock key to the index port. After that, index-port writes pick a register and data-port writes fill it. A second key value, written to the index port, seals the bank again. While the bank is sealed, every read returns all ones and every write except the unlock key is dropped.

One bit of the bank drives an output pin. Bit 7 of register 0xC1 enables a separate plug-and-play configuration block. The pin follows each data write that reaches that register. Reads are registered: the data and a valid flag appear one cycle after the read strobe.

Top module: `cfg_keyport`

## Requirements
- R1: After reset the bank is locked, the index is 0x00, all 256 registers read 0x00, `pnp_en_o` is low and `rvalid_o` is low.
- R2: While locked, a write of 0xAA to the index port (0x108) unlocks the bank. Every other write is dropped: it does not unlock the bank, does not change the index and does not change any register.
- R3: Any read of 0x108 or 0x109 while the bank is locked returns 0xFF.
- R4: While unlocked, a write of 0x55 to the index port locks the bank. The index and all register contents are kept across the lock and the next unlock.
- R5: While unlocked, any index-port write other than 0x55 becomes the new index, including 0xAA. An unlocked read of 0x108 returns the current index.
- R6: While unlocked, a write to the data port (0x109) stores the byte in the register at the current index. An unlocked read of 0x109 returns that register. Each of the 256 entries holds its own value.
- R7: `pnp_en_o` equals bit 7 of register 0xC1. It takes the new value on the cycle after a data-port write that reaches that register, and it changes at no other time.
- R8: A read or write at any address other than 0x108 and 0x109 is ignored. No state changes, and `rvalid_o` stays low for that read.
- R9: A read of 0x108 or 0x109 sets `rvalid_o` high, with `rdata_o` valid, for exactly the one cycle after `rd_i`. `rvalid_o` is low in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Host I/O address |
| wdata_i | input | 8 | Host write data |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| rdata_o | output | 8 | Read data, valid with rvalid_o |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_i |
| pnp_en_o | output | 1 | Plug-and-play configuration enable (register 0xC1 bit 7) |

## Verification
The hardest case to reach is a write that lands while the bank is sealed and looks like a real update. Examples are a data-port write, or an index write of anything but the key. The effect of such a write is hidden while the bank is locked, because every read returns 0xFF. So the stimulus re-locks the bank after storing known values, sends those writes, then unlocks and reads the index and the register back. Any change would show up there. The unlock key is also written while the bank is already open, to show that it then only loads the index.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam logic [ADDR_W-1:0] CFG_BASE = 16'h0108;
  localparam logic [DATA_W-1:0] KEY_OPEN = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_SEAL = 8'h55;
  localparam logic [DATA_W-1:0] PNP_REG = 8'hC1;
  localparam int unsigned PNP_BIT = 7;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_IDX,
    ACC_DAT
  } acc_e;
endpackage

// File: rtl/cfg_keyport_decode.sv
module cfg_keyport_decode
  import cfg_keyport_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter logic [AW-1:0] BASE = CFG_BASE
) (
  input  logic [AW-1:0] addr_i,
  output acc_e          acc_o
);
  localparam logic [AW-1:0] DAT_ADDR = BASE + AW'(1);

  always_comb begin
    if (addr_i == BASE) acc_o = ACC_IDX;
    else if (addr_i == DAT_ADDR) acc_o = ACC_DAT;
    else acc_o = ACC_NONE;
  end
endmodule

// File: rtl/cfg_keyport_ctl.sv
module cfg_keyport_ctl #(
  parameter int unsigned DW = 8,
  parameter logic [DW-1:0] KEY_OPEN = 8'hAA,
  parameter logic [DW-1:0] KEY_SEAL = 8'h55
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          idx_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          locked_o,
  output logic [DW-1:0] idx_o
);
  logic          locked_q;
  logic [DW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b1;
      idx_q    <= '0;
    end else if (idx_wr_i) begin
      if (locked_q) begin
        if (wdata_i == KEY_OPEN) locked_q <= 1'b0;
      end else if (wdata_i == KEY_SEAL) begin
        locked_q <= 1'b1;
      end else begin
        idx_q <= wdata_i;
      end
    end
  end

  assign locked_o = locked_q;
  assign idx_o    = idx_q;
endmodule

// File: rtl/cfg_keyport_bank.sv
module cfg_keyport_bank #(
  parameter int unsigned DW = 8,
  parameter int unsigned DEPTH = 256,
  parameter int unsigned TAP_IDX = 193,
  parameter int unsigned TAP_BIT = 7,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          tap_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
  assign tap_o   = mem_q[TAP_IDX][TAP_BIT];
endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
  import cfg_keyport_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter logic [AW-1:0] BASE = CFG_BASE,
  parameter logic [DW-1:0] OPEN_KEY = KEY_OPEN,
  parameter logic [DW-1:0] SEAL_KEY = KEY_SEAL,
  parameter logic [DW-1:0] EN_REG = PNP_REG,
  parameter int unsigned EN_BIT = PNP_BIT
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          pnp_en_o
);
  localparam int unsigned DEPTH = 2 ** DW;

  acc_e          acc;
  logic          lock_q;
  logic [DW-1:0] idx_q;
  logic [DW-1:0] bank_rd;
  logic          rvalid_q;
  logic [DW-1:0] rdata_q;

  cfg_keyport_decode #(.AW(AW), .BASE(BASE)) u_dec (
    .addr_i (addr_i),
    .acc_o  (acc)
  );

  cfg_keyport_ctl #(.DW(DW), .KEY_OPEN(OPEN_KEY), .KEY_SEAL(SEAL_KEY)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_wr_i (wr_i && acc == ACC_IDX),
    .wdata_i  (wdata_i),
    .locked_o (lock_q),
    .idx_o    (idx_q)
  );

  cfg_keyport_bank #(
    .DW(DW), .DEPTH(DEPTH), .TAP_IDX(int'(EN_REG)), .TAP_BIT(EN_BIT)
  ) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_i && acc == ACC_DAT && !lock_q),
    .idx_i   (idx_q),
    .wdata_i (wdata_i),
    .rdata_o (bank_rd),
    .tap_o   (pnp_en_o)
  );

  // reads sample state before any same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_i && acc != ACC_NONE;
      if (rd_i && acc != ACC_NONE) begin
        if (lock_q) rdata_q <= '1;
        else if (acc == ACC_IDX) rdata_q <= idx_q;
        else rdata_q <= bank_rd;
      end
    end
  end

  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/cfg_keyport_checker.sv
module cfg_keyport_checker
  import cfg_keyport_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rvalid_o,
  input logic              pnp_en_o,
  input logic              locked_i,
  input logic [DATA_W-1:0] idx_i
);
  logic in_idx, in_dat;
  assign in_idx = addr_i == CFG_BASE;
  assign in_dat = addr_i == CFG_BASE + 16'd1;

  AST_LOCKED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i && !(wr_i && in_idx && wdata_i == KEY_OPEN) |=> locked_i); // R2
  AST_LOCKED_IDX_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> $stable(idx_i)); // R2
  AST_LOCKED_READ_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && (in_idx || in_dat) && locked_i |=> rvalid_o && rdata_o == 8'hFF); // R3
  AST_SEAL_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i && wr_i && in_idx && wdata_i == KEY_SEAL |=> locked_i && $stable(idx_i)); // R4
  AST_INDEX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i && wr_i && in_idx && wdata_i != KEY_SEAL |=> !locked_i && idx_i == $past(wdata_i)); // R5
  AST_PNP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_i && wr_i && in_dat && idx_i == PNP_REG |=> pnp_en_o == $past(wdata_i[PNP_BIT])); // R7
  AST_PNP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && in_dat) |=> $stable(pnp_en_o)); // R7
  AST_OUT_OF_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_idx && !in_dat |=> !rvalid_o && $stable(locked_i) && $stable(idx_i)); // R8
  AST_NO_READ_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> !rvalid_o); // R9
endmodule

bind cfg_keyport cfg_keyport_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .wr_i     (wr_i),
  .rd_i     (rd_i),
  .rdata_o  (rdata_o),
  .rvalid_o (rvalid_o),
  .pnp_en_o (pnp_en_o),
  .locked_i (lock_q),
  .idx_i    (idx_q)
);

// File: tb/cfg_keyport_test.sv
module cfg_keyport_test;
  localparam time CLK_P = 20ns;
  localparam int NV = 34;
  // {kind, addr, data, expected read byte, expected pnp_en, requirement}
  // kind: 0 write, 1 read with valid, 2 read expecting no valid
  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [7:0]  exp;
    logic        pnp;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'd1, 16'h0108, 8'h00, 8'hFF, 1'b0, 4'd3},  // R3
    '{2'd0, 16'h0108, 8'h12, 8'h00, 1'b0, 4'd2},  // R2
    '{2'd0, 16'h0109, 8'h34, 8'h00, 1'b0, 4'd2},
    '{2'd1, 16'h0109, 8'h00, 8'hFF, 1'b0, 4'd3},
    '{2'd0, 16'h0108, 8'hAA, 8'h00, 1'b0, 4'd2},
    '{2'd1, 16'h0108, 8'h00, 8'h00, 1'b0, 4'd2},
    '{2'd1, 16'h0109, 8'h00, 8'h00, 1'b0, 4'd2},
    '{2'd0, 16'h0108, 8'h05, 8'h00, 1'b0, 4'd5},  // R5
    '{2'd0, 16'h0109, 8'h5A, 8'h00, 1'b0, 4'd6},  // R6
    '{2'd1, 16'h0109, 8'h00, 8'h5A, 1'b0, 4'd6},
    '{2'd1, 16'h0108, 8'h00, 8'h05, 1'b0, 4'd5},
    '{2'd0, 16'h0108, 8'hC1, 8'h00, 1'b0, 4'd5},
    '{2'd0, 16'h0109, 8'h80, 8'h00, 1'b1, 4'd7},  // R7
    '{2'd1, 16'h0109, 8'h00, 8'h80, 1'b1, 4'd7},
    '{2'd0, 16'h0109, 8'h7F, 8'h00, 1'b0, 4'd7},
    '{2'd0, 16'h0109, 8'hFF, 8'h00, 1'b1, 4'd7},
    '{2'd0, 16'h0108, 8'h55, 8'h00, 1'b1, 4'd4},  // R4
    '{2'd1, 16'h0108, 8'h00, 8'hFF, 1'b1, 4'd4},
    '{2'd0, 16'h0109, 8'h00, 8'h00, 1'b1, 4'd2},
    '{2'd0, 16'h0108, 8'h33, 8'h00, 1'b1, 4'd2},
    '{2'd0, 16'h0108, 8'hAA, 8'h00, 1'b1, 4'd4},
    '{2'd1, 16'h0108, 8'h00, 8'hC1, 1'b1, 4'd4},
    '{2'd1, 16'h0109, 8'h00, 8'hFF, 1'b1, 4'd4},
    '{2'd2, 16'h010A, 8'h00, 8'h00, 1'b1, 4'd8},  // R8
    '{2'd0, 16'h010A, 8'h00, 8'h00, 1'b1, 4'd8},
    '{2'd0, 16'h1109, 8'h00, 8'h00, 1'b1, 4'd8},
    '{2'd2, 16'h1108, 8'h00, 8'h00, 1'b1, 4'd8},
    '{2'd1, 16'h0109, 8'h00, 8'hFF, 1'b1, 4'd8},
    '{2'd0, 16'h0108, 8'hAA, 8'h00, 1'b1, 4'd5},
    '{2'd1, 16'h0108, 8'h00, 8'hAA, 1'b1, 4'd5},
    '{2'd0, 16'h0108, 8'hFF, 8'h00, 1'b1, 4'd6},
    '{2'd0, 16'h0109, 8'h3C, 8'h00, 1'b1, 4'd6},
    '{2'd1, 16'h0109, 8'h00, 8'h3C, 1'b1, 4'd6},
    '{2'd0, 16'h0108, 8'h05, 8'h00, 1'b1, 4'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rdata;
  logic        rvalid;
  logic        pnp_en;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  cfg_keyport uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .addr_i   (addr),
    .wdata_i  (wdata),
    .wr_i     (wr),
    .rd_i     (rd),
    .rdata_o  (rdata),
    .rvalid_o (rvalid),
    .pnp_en_o (pnp_en)
  );

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // returns {rvalid, rdata} sampled in the cycle after rd
  task automatic do_rd(logic [15:0] a, output logic [8:0] res);
    @(negedge clk);
    addr = a; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    res = {rvalid, rdata};
  endtask

  initial begin
    logic [8:0] r;
    #(CLK_P * 3);
    // R1 reset state
    check("R1 pnp_en", {8'h00, pnp_en}, 9'h000);
    check("R1 rvalid", {8'h00, rvalid}, 9'h000);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      if (VEC[i].kind == 2'd0) begin
        do_wr(VEC[i].addr, VEC[i].data);
      end else begin
        do_rd(VEC[i].addr, r);
        if (VEC[i].kind == 2'd1) check(tag, r, {1'b1, VEC[i].exp});
        else check(tag, {8'h00, r[8]}, 9'h000);
      end
      check({tag, " pnp"}, {8'h00, pnp_en}, {8'h00, VEC[i].pnp});
    end

    // R9: valid lasts one cycle only
    do_rd(16'h0108, r);
    @(negedge clk);
    check("R9 valid drop", {8'h00, rvalid}, 9'h000);

    // R1: reset from a busy state clears regs, index, lock and pnp_en
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 pnp after reset", {8'h00, pnp_en}, 9'h000);
    rst_n = 1'b1;
    do_rd(16'h0109, r);
    check("R1 locked after reset", r, 9'h1FF);
    do_wr(16'h0108, 8'hAA);
    do_rd(16'h0108, r);
    check("R1 index zero", r, 9'h100);
    do_wr(16'h0108, 8'hC1);
    do_rd(16'h0109, r);
    check("R1 reg C1 zero", r, 9'h100);
    do_wr(16'h0108, 8'hFF);
    do_rd(16'h0109, r);
    check("R1 reg FF zero", r, 9'h100);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule